// File: doc/BRIEF.md
# Two-Input Multicast Byte-Serializing Router

This block accepts messages on two independent input ports and delivers them to four output ports. A message is a 32-bit word plus a 4-bit destination mask. Bit i of the mask selects output i. One message may select several outputs, and each selected output then sends the word as four 8-bit beats, least significant byte first. Every port uses a valid/ready handshake. A transfer takes place only on a clock edge where valid and ready are both high.

Each input owns a one-message slot. The slot has two states, SLOT_EMPTY and SLOT_BUSY. In SLOT_EMPTY the input is ready. An accepted message with a non-zero mask moves the slot to SLOT_BUSY (transition LOAD). A message with a zero mask is taken and discarded, and the slot stays in SLOT_EMPTY (transition DROP). In SLOT_BUSY the slot clears one bit of its pending mask each time an output finishes its copy. When the last bit clears, the slot returns to SLOT_EMPTY (transition RELEASE).

Each output has its own serializer with two states, OUT_IDLE and OUT_SEND. In OUT_IDLE it uses round-robin to pick a requesting input (transition GRANT). In OUT_SEND it steps through four beats, and after the fourth beat is accepted it returns to OUT_IDLE (transition FINISH). A beat stays on the output while out_ready is low (STALL).

Top module: `mcast_byte_router`

## Requirements
- R1: An input message whose mask has only bit i set produces beats on output i and on no other output. Messages from the two inputs that go to different outputs proceed in parallel.
- R2: A message with several mask bits set is delivered in full to every selected output, and to no unselected output.
- R3: On an output, one message is exactly four accepted beats: out_data carries bits [7:0] in the first beat, [15:8] in the second, [23:16] in the third and [31:24] in the fourth.
- R4: A transfer occurs only on an edge where valid and ready are both high. in_ready for an input is high whenever its slot holds no message.
- R5: The four beats of one message on an output are contiguous. No beat of another message appears on that output between them.
- R6: When both inputs request the same output, a round-robin arbiter at that output chooses between them, and the choice changes only between messages. The first tie after reset goes to input 0. After that, priority passes to the input that was not granted last.
- R7: in_ready for an input stays low until every selected output has accepted the fourth beat of that input's message. It rises on the cycle after the last such acceptance.
- R8: A message with an all-zero mask is accepted, produces no beats on any output, and leaves in_ready high on the next cycle.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged on the next cycle.
- R10: While rst_n (active low, synchronous) is low, all out_valid bits go low. After reset both in_ready bits are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 2 | Per-input message valid |
| in_payload | input | 64 | Input words, input k at bits [32k+31:32k] |
| in_dest | input | 8 | Destination masks, input k at bits [4k+3:4k] |
| in_ready | output | 2 | Per-input ready |
| out_valid | output | 4 | Per-output beat valid |
| out_data | output | 32 | Beats, output j at bits [8j+7:8j] |
| out_ready | input | 4 | Per-output ready from the sink |

## Verification
The bench aims both inputs at the same output in the same cycle. It does this once straight after reset, and once after input 0 has just been served. An arbiter with the wrong tie-break or no rotation delivers the two words in the wrong order, and one that interleaves the messages mixes the bytes of the two words. A multicast message is held back on one output while another output finishes, to catch an input that is released early and overwrites a word that is still being sent. Random-looking backpressure on one output, a zero mask, and parallel unicast traffic expose a beat that changes during a stall, a dropped message that still emits beats or locks up its input, and a byte order that comes out reversed.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
    typedef enum logic {SLOT_EMPTY, SLOT_BUSY} slot_state_t;
    typedef enum logic {OUT_IDLE, OUT_SEND} ser_state_t;
endpackage

// File: rtl/mbr_in_slot.sv
module mbr_in_slot
    import mbr_pkg::*;
#(
    parameter int PW = 32,
    parameter int NO = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [PW-1:0] in_payload,
    input  logic [NO-1:0] in_dest,
    output logic          in_ready,
    input  logic [NO-1:0] done,
    output logic [NO-1:0] req,
    output logic [PW-1:0] held_payload
);
    slot_state_t   state_q, state_d;
    logic [NO-1:0] pend_q, pend_d;
    logic [PW-1:0] word_q, word_d;

    // next state: LOAD, DROP, RELEASE
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        word_d  = word_q;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (in_valid && (in_dest != '0)) begin
                    word_d  = in_payload;
                    pend_d  = in_dest;
                    state_d = SLOT_BUSY;
                end
            end
            SLOT_BUSY: begin
                pend_d = pend_q & ~done;
                if (pend_d == '0) state_d = SLOT_EMPTY;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
            pend_q  <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            word_q  <= word_d;
        end
    end

    always_comb begin
        in_ready     = (state_q == SLOT_EMPTY);
        req          = (state_q == SLOT_BUSY) ? pend_q : '0;
        held_payload = word_q;
    end
endmodule

// File: rtl/mbr_out_ser.sv
module mbr_out_ser
    import mbr_pkg::*;
#(
    parameter int NI = 2,
    parameter int PW = 32,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NI-1:0]    req,
    input  logic [NI*PW-1:0] words,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [BW-1:0]    out_data,
    output logic [NI-1:0]    done
);
    localparam int BEATS = PW / BW;
    localparam int CW    = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int GW    = (NI > 1) ? $clog2(NI) : 1;

    ser_state_t    state_q, state_d;
    logic [GW-1:0] gnt_q, gnt_d, last_q, last_d, pick;
    logic [CW-1:0] beat_q, beat_d;
    logic          pick_ok;
    logic          last_beat;

    // round-robin search starting after the last granted input
    always_comb begin
        pick_ok = 1'b0;
        pick    = '0;
        for (int k = 1; k <= NI; k++) begin
            int idx;
            idx = (int'(last_q) + k) % NI;
            if (!pick_ok && req[idx]) begin
                pick_ok = 1'b1;
                pick    = GW'(idx);
            end
        end
    end

    assign last_beat = (beat_q == CW'(BEATS - 1));

    // next state: GRANT, STALL, FINISH
    always_comb begin
        state_d = state_q;
        gnt_d   = gnt_q;
        last_d  = last_q;
        beat_d  = beat_q;
        unique case (state_q)
            OUT_IDLE: begin
                if (pick_ok) begin
                    gnt_d   = pick;
                    last_d  = pick;
                    beat_d  = '0;
                    state_d = OUT_SEND;
                end
            end
            OUT_SEND: begin
                if (out_ready) begin
                    if (last_beat) state_d = OUT_IDLE;
                    else           beat_d  = beat_q + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OUT_IDLE;
            gnt_q   <= '0;
            last_q  <= GW'(NI - 1);
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            gnt_q   <= gnt_d;
            last_q  <= last_d;
            beat_q  <= beat_d;
        end
    end

    always_comb begin
        out_valid = (state_q == OUT_SEND);
        out_data  = words[int'(gnt_q)*PW + int'(beat_q)*BW +: BW];
        done      = '0;
        if (out_valid && out_ready && last_beat) done[gnt_q] = 1'b1;
    end
endmodule

// File: rtl/mcast_byte_router.sv
module mcast_byte_router #(
    parameter int NI = 2,
    parameter int NO = 4,
    parameter int PW = 32,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NI-1:0]    in_valid,
    input  logic [NI*PW-1:0] in_payload,
    input  logic [NI*NO-1:0] in_dest,
    output logic [NI-1:0]    in_ready,
    output logic [NO-1:0]    out_valid,
    output logic [NO*BW-1:0] out_data,
    input  logic [NO-1:0]    out_ready
);
    logic [NO-1:0]    slot_req  [NI];
    logic [NO-1:0]    slot_done [NI];
    logic [NI-1:0]    ser_req   [NO];
    logic [NI-1:0]    ser_done  [NO];
    logic [NI*PW-1:0] held_all;

    for (genvar i = 0; i < NI; i++) begin : g_slot
        mbr_in_slot #(.PW(PW), .NO(NO)) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .in_valid     (in_valid[i]),
            .in_payload   (in_payload[i*PW +: PW]),
            .in_dest      (in_dest[i*NO +: NO]),
            .in_ready     (in_ready[i]),
            .done         (slot_done[i]),
            .req          (slot_req[i]),
            .held_payload (held_all[i*PW +: PW])
        );
    end

    for (genvar j = 0; j < NO; j++) begin : g_ser
        for (genvar i = 0; i < NI; i++) begin : g_x
            assign ser_req[j][i]  = slot_req[i][j];
            assign slot_done[i][j] = ser_done[j][i];
        end
        mbr_out_ser #(.NI(NI), .PW(PW), .BW(BW)) u_ser (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (ser_req[j]),
            .words     (held_all),
            .out_ready (out_ready[j]),
            .out_valid (out_valid[j]),
            .out_data  (out_data[j*BW +: BW]),
            .done      (ser_done[j])
        );
    end
endmodule

// File: rtl/mbr_checker.sv
module mbr_checker #(
    parameter int NI = 2,
    parameter int NO = 4,
    parameter int BW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NI-1:0]    in_valid,
    input logic [NI*NO-1:0] in_dest,
    input logic [NI-1:0]    in_ready,
    input logic [NO-1:0]    out_valid,
    input logic [NO*BW-1:0] out_data,
    input logic [NO-1:0]    out_ready
);
    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |=> (out_valid == '0));

    for (genvar i = 0; i < NI; i++) begin : g_in
        p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid[i] && in_ready[i] && (in_dest[i*NO +: NO] != '0)) |=> !in_ready[i]);
        p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid[i] && in_ready[i] && (in_dest[i*NO +: NO] == '0)) |=> in_ready[i]);
    end

    for (genvar j = 0; j < NO; j++) begin : g_out
        p_stall_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[j] && !out_ready[j]) |=> (out_valid[j] && $stable(out_data[j*BW +: BW])));
    end
endmodule

bind mcast_byte_router mbr_checker #(.NI(NI), .NO(NO), .BW(BW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_dest   (in_dest),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready)
);

// File: tb/sim_mcast_byte_router.sv
module sim_mcast_byte_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  in_valid = '0;
    logic [63:0] in_payload = '0;
    logic [7:0]  in_dest = '0;
    logic [3:0]  out_ready = 4'hF;
    wire  [1:0]  in_ready;
    wire  [3:0]  out_valid;
    wire  [31:0] out_data;

    int errors = 0;
    int checks = 0;
    logic [7:0] got_q [4][$];
    logic [3:0] stall_prev = '0;
    logic [31:0] data_prev = '0;

    always #2 clk = ~clk;

    mcast_byte_router u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_payload(in_payload),
        .in_dest(in_dest), .in_ready(in_ready), .out_valid(out_valid),
        .out_data(out_data), .out_ready(out_ready)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // capture accepted beats; R9 stall stability at the ports
    always @(negedge clk) begin
        if (rst_n) begin
            for (int j = 0; j < 4; j++) begin
                if (stall_prev[j]) begin
                    check(out_valid[j] == 1'b1, "R9", "valid dropped in stall", out_valid[j], 1);
                    check(out_data[j*8 +: 8] == data_prev[j*8 +: 8], "R9", "data moved in stall",
                          out_data[j*8 +: 8], data_prev[j*8 +: 8]);
                end
                if (out_valid[j] && out_ready[j]) got_q[j].push_back(out_data[j*8 +: 8]);
            end
            stall_prev = out_valid & ~out_ready;
            data_prev  = out_data;
        end else begin
            stall_prev = '0;
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R4", "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    task automatic clear_q();
        for (int j = 0; j < 4; j++) got_q[j].delete();
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic send(input logic [1:0] which, input logic [31:0] p0, input logic [31:0] p1,
                        input logic [3:0] d0, input logic [3:0] d1);
        logic [1:0] pend;
        logic [1:0] acc;
        @(posedge clk); #1;
        in_payload = {p1, p0};
        in_dest    = {d1, d0};
        in_valid   = which;
        pend       = which;
        for (int t = 0; t < 300 && pend != 0; t++) begin
            @(negedge clk);
            acc = pend & in_ready;
            @(posedge clk); #1;
            pend     = pend & ~acc;
            in_valid = pend;
        end
        check(pend == 0, "R4", "input never accepted", pend, 0);
    endtask

    task automatic expect_msg(input int port, input logic [31:0] p, input string req);
        for (int b = 0; b < 4; b++) begin
            if (got_q[port].size() == 0) begin
                check(1'b0, req, $sformatf("out%0d beat%0d missing", port, b), 0, p[b*8 +: 8]);
            end else begin
                logic [7:0] v;
                v = got_q[port].pop_front();
                check(v == p[b*8 +: 8], req, $sformatf("out%0d beat%0d", port, b), v, p[b*8 +: 8]);
            end
        end
    endtask

    task automatic expect_none(input int port, input string req);
        check(got_q[port].size() == 0, req, $sformatf("out%0d extra beats", port),
              got_q[port].size(), 0);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; in_valid = '0; out_ready = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 4'h0, "R10", "out_valid in reset", out_valid, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 2'b11, "R10", "in_ready after reset", in_ready, 3);
        clear_q();
    endtask

    task automatic t_unicast();
        clear_q();
        send(2'b01, 32'hA1B2C3D4, 32'h0, 4'b0100, 4'b0000);
        idle(12);
        expect_msg(2, 32'hA1B2C3D4, "R3");
        expect_none(0, "R1"); expect_none(1, "R1"); expect_none(3, "R1");
    endtask

    task automatic t_parallel();
        clear_q();
        send(2'b11, 32'h11223344, 32'h55667788, 4'b0001, 4'b0010);
        idle(12);
        expect_msg(0, 32'h11223344, "R1");
        expect_msg(1, 32'h55667788, "R1");
        expect_none(2, "R1"); expect_none(3, "R1");
    endtask

    task automatic t_multicast();
        clear_q();
        send(2'b10, 32'h0, 32'hDEADBEEF, 4'b0000, 4'b1011);
        idle(15);
        expect_msg(0, 32'hDEADBEEF, "R2");
        expect_msg(1, 32'hDEADBEEF, "R2");
        expect_msg(3, 32'hDEADBEEF, "R2");
        expect_none(2, "R2");
    endtask

    task automatic t_drop();
        clear_q();
        send(2'b01, 32'hCAFEF00D, 32'h0, 4'b0000, 4'b0000);
        @(negedge clk);
        check(in_ready[0] == 1'b1, "R8", "in_ready after zero mask", in_ready[0], 1);
        idle(10);
        for (int j = 0; j < 4; j++) expect_none(j, "R8");
    endtask

    task automatic t_tie_after_reset();
        do_reset();
        send(2'b11, 32'h0A0B0C0D, 32'hF1F2F3F4, 4'b0001, 4'b0001);
        idle(25);
        expect_msg(0, 32'h0A0B0C0D, "R6");
        expect_msg(0, 32'hF1F2F3F4, "R5");
    endtask

    task automatic t_rotate();
        do_reset();
        send(2'b01, 32'h01020304, 32'h0, 4'b0001, 4'b0000);
        idle(12);
        clear_q();
        send(2'b11, 32'h90919293, 32'hE0E1E2E3, 4'b0001, 4'b0001);
        idle(25);
        expect_msg(0, 32'hE0E1E2E3, "R6");
        expect_msg(0, 32'h90919293, "R5");
    endtask

    task automatic t_backpressure();
        clear_q();
        fork
            begin
                for (int c = 0; c < 60; c++) begin
                    @(posedge clk); #1;
                    out_ready[1] = ((c % 3) == 0) || ((c % 7) == 5);
                end
                @(posedge clk); #1;
                out_ready[1] = 1'b1;
            end
            send(2'b10, 32'h0, 32'h5A6B7C8D, 4'b0000, 4'b0010);
        join
        idle(10);
        expect_msg(1, 32'h5A6B7C8D, "R9");
    endtask

    task automatic t_release();
        clear_q();
        @(posedge clk); #1;
        out_ready[3] = 1'b0;
        send(2'b01, 32'h13579BDF, 32'h0, 4'b1001, 4'b0000);
        idle(12);
        expect_msg(0, 32'h13579BDF, "R7");
        @(negedge clk);
        check(in_ready[0] == 1'b0, "R7", "released before out3 done", in_ready[0], 0);
        @(posedge clk); #1;
        out_ready[3] = 1'b1;
        idle(10);
        @(negedge clk);
        check(in_ready[0] == 1'b1, "R7", "not released after all done", in_ready[0], 1);
        expect_msg(3, 32'h13579BDF, "R7");
    endtask

    initial begin
        do_reset();
        t_unicast();
        t_parallel();
        t_multicast();
        t_drop();
        t_tie_after_reset();
        t_rotate();
        t_backpressure();
        t_release();
        idle(5);
        summary();
        $finish;
    end
endmodule